// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block models the command-driven front end of a parallel NOR flash. A host reaches it through a simple synchronous slave port. Each write cycle is either a new command byte or one step of a command already in progress. Each read cycle returns array data, the status byte, an identifier word or a query-table byte, depending on the command that was accepted last. The storage array is a byte memory inside the block. Program, erase and lock operations finish in the cycle of their final bus write, so the ready flag is never seen low.

Accesses are 1, 2 or 4 bytes wide and must be aligned to their width. For multi-byte accesses, an endianness input selects whether the lowest-addressed byte sits in the most or the least significant lane. A write-protect input turns every array-modifying step into an error report, and the array is left as it was.

Top module: `pfc_flash_cui`

## Requirements
- R1: After reset the sequence phase, current command and status are all 0, every array byte reads 0xFF, and reads return array data. Read data appears on `rd_data` with `rd_valid` high in the cycle after `bus_rd`.
- R2: In the command phase, a write of 0x40 or 0x10 arms one program. The next write stores its data at its address using the access width and endianness, sets status bit 7 and returns to the command phase.
- R3: Command 0x20 fills with 0xFF the whole sector that holds the address (the address with its low log2(SECTOR_BYTES) bits cleared) and sets status bit 7. A following 0xD0 confirms it, while 0xFF or any other value returns to array reads.
- R4: Command 0xE8 sets status bit 7. The next write supplies a count N, and N+1 data writes follow, each programmed like R2. After the last data write only 0xD0 is accepted, and it returns to the command phase with status bit 7 set.
- R5: Command 0x60 followed by 0xD0 or 0x01 completes with status bit 7 set. Any other second value returns to array reads.
- R6: Command 0x50 clears the whole status byte and returns to array reads. Commands 0xFF, 0xF0 and 0x00 return to array reads and leave the status unchanged.
- R7: After command 0x70, and while 0x10, 0x20, 0x40, 0x60 or 0xE8 is the current command, reads return the status byte in bits 7:0 with zeros above.
- R8: After command 0x90, reads use the index address[7:0] shifted right by 0, 1 or 2 for widths 1, 2 or 4. Index 0 returns the 16-bit manufacturer code, index 1 the 16-bit device code, and any other index returns 0.
- R9: After command 0x98, reads return query-table bytes at the same index. The table holds 0x51 0x52 0x59 at indices 0x10 to 0x12, 0x01 0x00 at 0x13 to 0x14, and log2 of the array size at 0x27. Indices of 0x52 and above return 0. Only 0xFF leaves query mode, and any other write is ignored.
- R10: With `read_only` high, program and buffered-write data steps set status bit 4 and erase sets status bit 5. The array is unchanged and bit 7 is still set. Bits 4 and 5 stay set until a 0x50 command.
- R11: An unknown command byte, or an unexpected value in a later step, returns the phase and command to 0 (array reads).
- R12: In multi-byte array accesses, the byte at the lowest address goes to the most significant lane when `big_endian` is high, and to the least significant lane otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per bus write |
| bus_rd | input | 1 | Read strobe, one cycle per bus read |
| bus_addr | input | ADDR_W | Byte address, aligned to the access width |
| bus_wdata | input | 32 | Write data; bits 7:0 carry command bytes |
| bus_size | input | 2 | Access width: 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes |
| big_endian | input | 1 | Lane order for multi-byte array accesses |
| read_only | input | 1 | Write protect; modifying steps set error bits instead |
| rd_data | output | 32 | Registered read data |
| rd_valid | output | 1 | High in the cycle after `bus_rd` |

## Verification
The assertions assume that `bus_wr` and `bus_rd` are never high in the same cycle, that addresses are aligned to the access width, and that `read_only` does not change in the middle of a command sequence. The bench drives each strobe for exactly one cycle with an idle cycle between accesses. It changes `read_only` and `big_endian` only while the sequencer is in array-read mode and only uses aligned addresses, so every property sees well-formed traffic.

// File: rtl/pfc_pkg.sv
package pfc_pkg;

  typedef enum logic [1:0] {
    PH_CMD  = 2'd0,
    PH_ARG  = 2'd1,
    PH_DATA = 2'd2,
    PH_CONF = 2'd3
  } phase_t;

  typedef enum logic [1:0] {
    RM_ARRAY  = 2'd0,
    RM_STATUS = 2'd1,
    RM_IDENT  = 2'd2,
    RM_QUERY  = 2'd3
  } rmode_t;

  localparam logic [7:0] OP_NULL    = 8'h00;
  localparam logic [7:0] OP_UNLOCK  = 8'h01;
  localparam logic [7:0] OP_PROG_A  = 8'h10;
  localparam logic [7:0] OP_ERASE   = 8'h20;
  localparam logic [7:0] OP_PROG_B  = 8'h40;
  localparam logic [7:0] OP_CLR     = 8'h50;
  localparam logic [7:0] OP_LOCK    = 8'h60;
  localparam logic [7:0] OP_STAT    = 8'h70;
  localparam logic [7:0] OP_IDENT   = 8'h90;
  localparam logic [7:0] OP_QUERY   = 8'h98;
  localparam logic [7:0] OP_CONFIRM = 8'hD0;
  localparam logic [7:0] OP_BUF     = 8'hE8;
  localparam logic [7:0] OP_ALT     = 8'hF0;
  localparam logic [7:0] OP_ARRAY   = 8'hFF;

  localparam int ST_READY     = 7;
  localparam int ST_ERASE_ERR = 5;
  localparam int ST_PROG_ERR  = 4;

  // number of byte lanes for a size code
  function automatic int lanes(logic [1:0] sz);
    case (sz)
      2'd0:    return 1;
      2'd1:    return 2;
      default: return 4;
    endcase
  endfunction

  // lane that memory byte k of an access occupies
  function automatic int lane_pos(int k, int nl, logic be);
    int p;
    p = be ? (nl - 1 - k) : k;
    return p & 3;
  endfunction

endpackage

// File: rtl/pfc_seq.sv
module pfc_seq
  import pfc_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr,
  input  logic [31:0] wdata,
  input  logic        read_only,
  output phase_t      phase,
  output logic [7:0]  cmd,
  output logic [7:0]  status,
  output logic        prog_we,
  output logic        erase_we,
  output rmode_t      rmode
);

  logic [CNT_W-1:0] cnt, cnt_n;
  phase_t           ph_n;
  logic [7:0]       cmd_n, st_n;
  logic [7:0]       op;

  assign op = wdata[7:0];

  always_comb begin
    ph_n     = phase;
    cmd_n    = cmd;
    st_n     = status;
    cnt_n    = cnt;
    prog_we  = 1'b0;
    erase_we = 1'b0;
    if (wr) begin
      case (phase)
        PH_CMD: begin
          case (op)
            OP_NULL, OP_ALT, OP_ARRAY: cmd_n = OP_NULL;
            OP_CLR: begin
              st_n  = '0;
              cmd_n = OP_NULL;
            end
            OP_PROG_A, OP_PROG_B, OP_LOCK, OP_QUERY: begin
              ph_n  = PH_ARG;
              cmd_n = op;
            end
            OP_ERASE: begin
              if (read_only) st_n[ST_ERASE_ERR] = 1'b1;
              else           erase_we = 1'b1;
              st_n[ST_READY] = 1'b1;
              ph_n  = PH_ARG;
              cmd_n = op;
            end
            OP_BUF: begin
              st_n[ST_READY] = 1'b1;
              ph_n  = PH_ARG;
              cmd_n = op;
            end
            OP_STAT, OP_IDENT: cmd_n = op;
            default: cmd_n = OP_NULL;
          endcase
        end
        PH_ARG: begin
          ph_n = PH_CMD;
          case (cmd)
            OP_PROG_A, OP_PROG_B: begin
              if (read_only) st_n[ST_PROG_ERR] = 1'b1;
              else           prog_we = 1'b1;
              st_n[ST_READY] = 1'b1;
            end
            OP_ERASE: begin
              if (op == OP_CONFIRM) st_n[ST_READY] = 1'b1;
              else                  cmd_n = OP_NULL;
            end
            OP_LOCK: begin
              if (op == OP_CONFIRM || op == OP_UNLOCK) st_n[ST_READY] = 1'b1;
              else                                     cmd_n = OP_NULL;
            end
            OP_BUF: begin
              cnt_n = wdata[CNT_W-1:0];
              ph_n  = PH_DATA;
            end
            OP_QUERY: begin
              if (op == OP_ARRAY) cmd_n = OP_NULL;
              else                ph_n  = PH_ARG;
            end
            default: cmd_n = OP_NULL;
          endcase
        end
        PH_DATA: begin
          if (cmd == OP_BUF) begin
            if (read_only) st_n[ST_PROG_ERR] = 1'b1;
            else           prog_we = 1'b1;
            st_n[ST_READY] = 1'b1;
            if (cnt == '0) ph_n = PH_CONF;
            cnt_n = cnt - CNT_W'(1);
          end else begin
            ph_n  = PH_CMD;
            cmd_n = OP_NULL;
          end
        end
        default: begin
          ph_n = PH_CMD;
          if (cmd == OP_BUF && op == OP_CONFIRM) st_n[ST_READY] = 1'b1;
          else                                   cmd_n = OP_NULL;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase  <= PH_CMD;
      cmd    <= OP_NULL;
      status <= '0;
      cnt    <= '0;
    end else begin
      phase  <= ph_n;
      cmd    <= cmd_n;
      status <= st_n;
      cnt    <= cnt_n;
    end
  end

  always_comb begin
    case (cmd)
      OP_NULL:  rmode = RM_ARRAY;
      OP_IDENT: rmode = RM_IDENT;
      OP_QUERY: rmode = RM_QUERY;
      default:  rmode = RM_STATUS;
    endcase
  end

  AST_PROG_READY: assert property (@(posedge clk) disable iff (rst)
    wr && phase == PH_ARG && (cmd == OP_PROG_A || cmd == OP_PROG_B)
    |=> status[ST_READY] && phase == PH_CMD); // R2
  AST_ERASE_CONFIRM: assert property (@(posedge clk) disable iff (rst)
    wr && phase == PH_ARG && cmd == OP_ERASE && op == OP_CONFIRM
    |=> phase == PH_CMD && status[ST_READY]); // R3
  AST_BUF_LAST_BEAT: assert property (@(posedge clk) disable iff (rst)
    wr && phase == PH_DATA && cmd == OP_BUF && cnt == '0 |=> phase == PH_CONF); // R4
  AST_CLEAR_STATUS: assert property (@(posedge clk) disable iff (rst)
    wr && phase == PH_CMD && op == OP_CLR |=> status == 8'h00 && rmode == RM_ARRAY); // R6
  AST_QUERY_HOLD: assert property (@(posedge clk) disable iff (rst)
    wr && cmd == OP_QUERY && phase == PH_ARG && op != OP_ARRAY |=> cmd == OP_QUERY); // R9
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    $fell(status[ST_PROG_ERR]) |-> $past(wr && phase == PH_CMD && op == OP_CLR)); // R10
  AST_UNKNOWN_OP: assert property (@(posedge clk) disable iff (rst)
    wr && phase == PH_CMD && op == 8'h33 |=> cmd == OP_NULL && phase == PH_CMD); // R11

endmodule

// File: rtl/pfc_array.sv
module pfc_array
  import pfc_pkg::*;
#(
  parameter int ADDR_W       = 8,
  parameter int SECTOR_BYTES = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic              erase,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  input  logic [1:0]        size,
  input  logic              big_endian,
  output logic [31:0]       rdata
);

  localparam int DEPTH  = 1 << ADDR_W;
  localparam int SEC_AW = $clog2(SECTOR_BYTES);

  logic [7:0] mem [DEPTH];
  int         nl;

  assign nl = lanes(size);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else begin
      if (erase) begin
        for (int i = 0; i < DEPTH; i++)
          if ((ADDR_W'(i) >> SEC_AW) == (addr >> SEC_AW)) mem[i] <= 8'hFF;
      end
      if (we) begin
        for (int k = 0; k < 4; k++)
          if (k < nl)
            mem[addr + ADDR_W'(k)] <= wdata[8*lane_pos(k, nl, big_endian) +: 8];
      end
    end
  end

  always_comb begin
    rdata = '0;
    for (int k = 0; k < 4; k++)
      if (k < nl)
        rdata[8*lane_pos(k, nl, big_endian) +: 8] = mem[addr + ADDR_W'(k)];
  end

  AST_ERASE_FILL: assert property (@(posedge clk) disable iff (rst)
    erase && !we |=> mem[$past(addr)] == 8'hFF); // R3

endmodule

// File: rtl/pfc_query_rom.sv
module pfc_query_rom #(
  parameter int         ADDR_W       = 8,
  parameter int         SECTOR_BYTES = 64,
  parameter int         BUF_LOG2     = 5,
  parameter logic [7:0] QRY_LEN      = 8'h52
) (
  input  logic [7:0] idx,
  output logic [7:0] data
);

  localparam int NBLK = (1 << ADDR_W) / SECTOR_BYTES;

  function automatic logic [7:0] entry(logic [7:0] i);
    case (i)
      8'h10: return 8'h51;
      8'h11: return 8'h52;
      8'h12: return 8'h59;
      8'h13: return 8'h01;
      8'h15: return 8'h31;
      8'h1B: return 8'h45;
      8'h1C: return 8'h55;
      8'h1F: return 8'h07;
      8'h20: return 8'h07;
      8'h21: return 8'h0A;
      8'h23: return 8'h04;
      8'h24: return 8'h04;
      8'h25: return 8'h04;
      8'h27: return 8'(ADDR_W);
      8'h28: return 8'h02;
      8'h2A: return 8'(BUF_LOG2);
      8'h2C: return 8'h01;
      8'h2D: return 8'(NBLK - 1);
      8'h2E: return 8'((NBLK - 1) >> 8);
      8'h2F: return 8'(SECTOR_BYTES >> 8);
      8'h30: return 8'(SECTOR_BYTES >> 16);
      8'h31: return 8'h50;
      8'h32: return 8'h52;
      8'h33: return 8'h49;
      8'h34: return 8'h31;
      8'h35: return 8'h30;
      8'h3F: return 8'h01;
      default: return 8'h00;
    endcase
  endfunction

  assign data = (idx < QRY_LEN) ? entry(idx) : 8'h00;

endmodule

// File: rtl/pfc_flash_cui.sv
module pfc_flash_cui
  import pfc_pkg::*;
#(
  parameter int          ADDR_W       = 8,
  parameter int          SECTOR_BYTES = 64,
  parameter int          CNT_W        = 8,
  parameter int          BUF_LOG2     = 5,
  parameter logic [15:0] MFR_CODE     = 16'h8900,
  parameter logic [15:0] DEV_CODE     = 16'h0018
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic [1:0]        bus_size,
  input  logic              big_endian,
  input  logic              read_only,
  output logic [31:0]       rd_data,
  output logic              rd_valid
);

  phase_t      phase;
  rmode_t      rmode;
  logic [7:0]  cmd, status, qbyte, boff, idx;
  logic        prog_we, erase_we;
  logic [31:0] arr_rdata, id_word;

  pfc_seq #(.CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst(rst), .wr(bus_wr), .wdata(bus_wdata),
    .read_only(read_only), .phase(phase), .cmd(cmd), .status(status),
    .prog_we(prog_we), .erase_we(erase_we), .rmode(rmode)
  );

  pfc_array #(.ADDR_W(ADDR_W), .SECTOR_BYTES(SECTOR_BYTES)) u_array (
    .clk(clk), .rst(rst), .we(prog_we), .erase(erase_we), .addr(bus_addr),
    .wdata(bus_wdata), .size(bus_size), .big_endian(big_endian),
    .rdata(arr_rdata)
  );

  assign boff = 8'(bus_addr);
  assign idx  = (bus_size == 2'd0) ? boff :
                (bus_size == 2'd1) ? (boff >> 1) : (boff >> 2);

  pfc_query_rom #(
    .ADDR_W(ADDR_W), .SECTOR_BYTES(SECTOR_BYTES), .BUF_LOG2(BUF_LOG2)
  ) u_rom (
    .idx(idx), .data(qbyte)
  );

  always_comb begin
    case (idx)
      8'd0:    id_word = {16'h0000, MFR_CODE};
      8'd1:    id_word = {16'h0000, DEV_CODE};
      default: id_word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= bus_rd;
      if (bus_rd) begin
        case (rmode)
          RM_ARRAY:  rd_data <= arr_rdata;
          RM_STATUS: rd_data <= {24'h0, status};
          RM_IDENT:  rd_data <= id_word;
          default:   rd_data <= {24'h0, qbyte};
        endcase
      end
    end
  end

  AST_RO_NO_ARRAY: assert property (@(posedge clk) disable iff (rst)
    read_only |-> !(prog_we || erase_we)); // R10
  AST_STATUS_UPPER: assert property (@(posedge clk) disable iff (rst)
    bus_rd && rmode == RM_STATUS |=> rd_data[31:8] == 24'h0); // R7
  AST_RD_VALID: assert property (@(posedge clk) disable iff (rst)
    bus_rd |=> rd_valid); // R1

endmodule

// File: tb/test_pfc_flash_cui.sv
module test_pfc_flash_cui;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [1:0]  bus_size = '0;
  logic        big_endian = 1'b0, read_only = 1'b0;
  logic [31:0] rd_data;
  logic        rd_valid;
  int          n_chk = 0, n_err = 0;

  always #5 clk = ~clk;

  pfc_flash_cui i_pfc_flash_cui (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_size(bus_size),
    .big_endian(big_endian), .read_only(read_only),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bwr(input logic [7:0] a, input logic [31:0] d, input logic [1:0] sz);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_size = sz; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rdchk(input string tag, input logic [7:0] a, input logic [1:0] sz,
                       input logic [31:0] exp);
    @(negedge clk);
    bus_addr = a; bus_size = sz; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    check(tag, rd_data, exp);
  endtask

  task automatic t_reset;
    check("R1 rd_valid idle", {31'b0, rd_valid}, 32'h0);
    @(negedge clk);
    bus_addr = 8'h00; bus_size = 2'd2; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    check("R1 rd_valid after read", {31'b0, rd_valid}, 32'h1);
    check("R1 erased array after reset", rd_data, 32'hFFFF_FFFF);
  endtask

  task automatic t_program;
    bwr(8'h00, 32'h50, 0);
    bwr(8'h10, 32'h40, 0);
    bwr(8'h10, 32'hA5, 0);
    rdchk("R7 status after program", 8'h10, 0, 32'h80);
    bwr(8'h00, 32'hFF, 0);
    rdchk("R2 programmed byte 0x40", 8'h10, 0, 32'hA5);
    bwr(8'h40, 32'h10, 0);
    bwr(8'h40, 32'h12, 0);
    bwr(8'h00, 32'hFF, 0);
    rdchk("R2 programmed byte 0x10", 8'h40, 0, 32'h12);
  endtask

  task automatic t_endian;
    bwr(8'h20, 32'h40, 0);
    bwr(8'h20, 32'h1122_3344, 2);
    bwr(8'h00, 32'hFF, 0);
    rdchk("R12 LE low byte", 8'h20, 0, 32'h44);
    rdchk("R12 LE high byte", 8'h23, 0, 32'h11);
    big_endian = 1'b1;
    bwr(8'h24, 32'h40, 0);
    bwr(8'h24, 32'h5566_7788, 2);
    bwr(8'h00, 32'hFF, 0);
    rdchk("R12 BE low byte", 8'h24, 0, 32'h55);
    rdchk("R12 BE halfword", 8'h24, 1, 32'h5566);
    big_endian = 1'b0;
    rdchk("R12 LE halfword", 8'h24, 1, 32'h6655);
    rdchk("R12 LE word", 8'h24, 2, 32'h8877_6655);
  endtask

  task automatic t_erase;
    bwr(8'h00, 32'h50, 0);
    bwr(8'h05, 32'h20, 0);
    bwr(8'h05, 32'hD0, 0);
    rdchk("R3 status after erase", 8'h05, 0, 32'h80);
    bwr(8'h00, 32'hFF, 0);
    rdchk("R3 sector word erased", 8'h20, 2, 32'hFFFF_FFFF);
    rdchk("R3 sector byte erased", 8'h10, 0, 32'hFF);
    rdchk("R3 next sector kept", 8'h40, 0, 32'h12);
    bwr(8'hC0, 32'h20, 0);
    bwr(8'hC0, 32'hFF, 0);
    rdchk("R3 abort to array", 8'hC0, 0, 32'hFF);
    bwr(8'hC0, 32'h20, 0);
    bwr(8'hC0, 32'h33, 0);
    rdchk("R3 bad confirm to array", 8'hC0, 0, 32'hFF);
  endtask

  task automatic t_buffer;
    bwr(8'h00, 32'h50, 0);
    bwr(8'h80, 32'hE8, 0);
    bwr(8'h80, 32'h02, 0);
    bwr(8'h80, 32'hA1, 0);
    bwr(8'h81, 32'hA2, 0);
    bwr(8'h82, 32'hA3, 0);
    bwr(8'h80, 32'hD0, 0);
    rdchk("R4 status after confirm", 8'h80, 0, 32'h80);
    bwr(8'h00, 32'hFF, 0);
    rdchk("R4 three beats stored", 8'h80, 2, 32'hFFA3_A2A1);
    bwr(8'h88, 32'hE8, 0);
    bwr(8'h88, 32'h00, 0);
    bwr(8'h88, 32'hBEEF, 1);
    bwr(8'h88, 32'hD0, 0);
    bwr(8'h00, 32'hFF, 0);
    rdchk("R4 count zero single beat", 8'h88, 1, 32'hBEEF);
  endtask

  task automatic t_lock;
    bwr(8'h00, 32'h50, 0);
    bwr(8'h00, 32'h60, 0);
    bwr(8'h00, 32'h01, 0);
    rdchk("R5 unlock status", 8'h40, 0, 32'h80);
    bwr(8'h00, 32'h50, 0);
    bwr(8'h00, 32'h60, 0);
    bwr(8'h00, 32'hD0, 0);
    rdchk("R5 lock status", 8'h40, 0, 32'h80);
    bwr(8'h00, 32'h60, 0);
    bwr(8'h00, 32'h77, 0);
    rdchk("R5 bad second write to array", 8'h40, 0, 32'h12);
  endtask

  task automatic t_clear;
    bwr(8'h00, 32'h70, 0);
    rdchk("R7 read status mode", 8'h40, 0, 32'h80);
    bwr(8'h00, 32'h50, 0);
    rdchk("R6 clear returns to array", 8'h40, 0, 32'h12);
    bwr(8'h00, 32'h70, 0);
    rdchk("R6 status cleared", 8'h40, 0, 32'h00);
    bwr(8'h00, 32'hF0, 0);
    rdchk("R6 0xF0 to array", 8'h40, 0, 32'h12);
    bwr(8'h00, 32'h70, 0);
    bwr(8'h00, 32'h00, 0);
    rdchk("R6 0x00 to array", 8'h40, 0, 32'h12);
  endtask

  task automatic t_ident;
    bwr(8'h00, 32'h90, 0);
    rdchk("R8 manufacturer", 8'h00, 1, 32'h8900);
    rdchk("R8 device halfword", 8'h02, 1, 32'h0018);
    rdchk("R8 device byte", 8'h01, 0, 32'h0018);
    rdchk("R8 device word", 8'h04, 2, 32'h0018);
    rdchk("R8 other index", 8'h08, 1, 32'h0);
    bwr(8'h00, 32'hFF, 0);
  endtask

  task automatic t_query;
    bwr(8'h00, 32'h98, 0);
    rdchk("R9 Q", 8'h10, 0, 32'h51);
    rdchk("R9 R", 8'h11, 0, 32'h52);
    rdchk("R9 Y", 8'h12, 0, 32'h59);
    rdchk("R9 cmdset halfword index", 8'h26, 1, 32'h01);
    rdchk("R9 cmdset high", 8'h14, 0, 32'h00);
    rdchk("R9 size log2", 8'h27, 0, 32'h08);
    rdchk("R9 past table", 8'h52, 0, 32'h00);
    bwr(8'h00, 32'h70, 0);
    rdchk("R9 other write ignored", 8'h12, 0, 32'h59);
    bwr(8'h00, 32'hFF, 0);
    rdchk("R9 leave query", 8'h40, 0, 32'h12);
  endtask

  task automatic t_readonly;
    read_only = 1'b1;
    bwr(8'h00, 32'h50, 0);
    bwr(8'h90, 32'h40, 0);
    bwr(8'h90, 32'h5A, 0);
    rdchk("R10 program error status", 8'h90, 0, 32'h90);
    bwr(8'h00, 32'hFF, 0);
    rdchk("R10 array untouched by program", 8'h90, 0, 32'hFF);
    bwr(8'h00, 32'h50, 0);
    bwr(8'h40, 32'h20, 0);
    bwr(8'h40, 32'hD0, 0);
    rdchk("R10 erase error status", 8'h40, 0, 32'hA0);
    bwr(8'h00, 32'hFF, 0);
    rdchk("R10 array untouched by erase", 8'h40, 0, 32'h12);
    bwr(8'h00, 32'h50, 0);
    bwr(8'h98, 32'hE8, 0);
    bwr(8'h98, 32'h00, 0);
    bwr(8'h98, 32'h66, 0);
    bwr(8'h98, 32'hD0, 0);
    rdchk("R10 buffer error status", 8'h98, 0, 32'h90);
    bwr(8'h00, 32'hFF, 0);
    rdchk("R10 buffer byte untouched", 8'h98, 0, 32'hFF);
    read_only = 1'b0;
    bwr(8'h99, 32'h40, 0);
    bwr(8'h99, 32'h77, 0);
    rdchk("R10 error bit sticky", 8'h99, 0, 32'h90);
    bwr(8'h00, 32'hFF, 0);
  endtask

  task automatic t_unknown;
    bwr(8'h00, 32'h50, 0);
    bwr(8'h00, 32'h70, 0);
    bwr(8'h00, 32'h33, 0);
    rdchk("R11 unknown command to array", 8'h40, 0, 32'h12);
    bwr(8'h9A, 32'hE8, 0);
    bwr(8'h9A, 32'h00, 0);
    bwr(8'h9A, 32'h11, 0);
    bwr(8'h9A, 32'h22, 0);
    rdchk("R11 bad confirm to array", 8'h9A, 0, 32'h11);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_program();
    t_endian();
    t_erase();
    t_buffer();
    t_lock();
    t_clear();
    t_ident();
    t_query();
    t_readonly();
    t_unknown();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule